// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer

This block turns single transfer requests from a processor core into timed external bus cycles on an 8-bit data, 16-bit address bus. Four cycle kinds are supported: memory read, memory write, port read and port write. Each is built from whole clock periods called T-states. The rising clock edge moves the sequencer from one T-state to the next. The falling edge updates the active-low strobes, so strobe transitions fall half a T-state away from the points where the address and data may change.

The core presents a request with a 2-bit kind code, an address and write data. The block drives the address, the data output with its enable, a memory select, a port select, a read strobe and a write strobe. It samples an active-low wait input to stretch the cycle. When the cycle ends, the block returns the captured read data and a one-clock done pulse. Port cycles always receive one extra wait state, and the wait input is sampled inside that state.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is held and after it is released with no request, memSelN, ioSelN, rdN and wrN are high, busDoutEn is 0, rspDone is 0, and busAddr, busDout and rspRdata are 0.
- R2: reqType[1] selects the target: 1 means a port cycle, which uses ioSelN, and 0 means a memory cycle, which uses memSelN. reqType[0] selects the direction: 1 means write and 0 means read. The two selects are never low at the same time.
- R3: A memory cycle with waitN high lasts three T-states (T1, T2, T3). The rising edge that samples reqValid high in idle starts T1, and rspDone is high during the clock period after T3.
- R4: A port cycle always adds one automatic wait state after T2, whatever the level of waitN, so with waitN high it lasts four T-states.
- R5: waitN is sampled on the rising edge that ends T2 of a memory cycle, the automatic wait state of a port cycle, or any added wait state. Each time it is found low, one further wait state is inserted before T3.
- R6: Strobes change only at falling edges. The select and, on reads, rdN go low at the falling edge inside T1. They return high at the first falling edge after the last T-state.
- R7: On writes, wrN goes low at the falling edge inside T2 and stays low through every wait state. It returns high at the falling edge inside T3, half a T-state before the cycle ends. rdN and wrN are never low together.
- R8: busAddr and busDout load from reqAddr and reqWdata on the accepting edge and hold until the next accepted request. busDoutEn is high from T1 through the last T-state of write cycles only.
- R9: On reads, busDin is captured into rspRdata on the rising edge that ends T3. rspDone is a single-period pulse, and rspRdata holds its value until the next read completes.
- R10: A request that arrives while a cycle is in progress is ignored. The address, data and strobes of the running cycle do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge steps T-states, falling edge updates strobes |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Core request, taken only when idle |
| reqType | input | 2 | [1] port/memory, [0] write/read |
| reqAddr | input | 16 | Request address |
| reqWdata | input | 8 | Write data |
| rspRdata | output | 8 | Captured read data |
| rspDone | output | 1 | One-period cycle completion pulse |
| busAddr | output | 16 | External address bus |
| busDout | output | 8 | External data output |
| busDoutEn | output | 1 | Data output enable |
| busDin | input | 8 | External data input |
| memSelN | output | 1 | Active-low memory select |
| ioSelN | output | 1 | Active-low port select |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |
| waitN | input | 1 | Active-low wait request |

## Verification
The bench targets the boundary between the automatic port wait state and the sampled waits. A design that samples waitN in T2 of a port cycle, or that skips the automatic state, would give port cycles that are one state too long or too short. The bench also checks that wrN returns high inside T3 while the address and data stay put; a write strobe released on the rising edge would race the address change. Requests issued mid-cycle and back-to-back requests expose a sequencer that restarts when busy or that misses the idle period.

// File: rtl/bus_cycle_pkg.sv
package bus_cycle_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_TIO,
    ST_TW,
    ST_T3
  } tState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic load;     // accept request: latch address and data
    logic doutEn;   // write cycle in progress
    logic finish;   // final T-state ends at next rising edge
    logic capRead;  // final T-state of a read cycle
  } dpStrb_t;

endpackage

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bus_cycle_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqType,
  input  logic       waitN,
  output dpStrb_t    strb,
  output logic       memSelN,
  output logic       ioSelN,
  output logic       rdN,
  output logic       wrN
);

  tState_e state, stateNext;
  logic    isIo, isWr;
  logic    busy, accept;

  assign busy   = (state != ST_IDLE);
  assign accept = (state == ST_IDLE) && reqValid;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid) stateNext = ST_T1;
      ST_T1:   stateNext = ST_T2;
      ST_T2:   stateNext = isIo ? ST_TIO : (waitN ? ST_T3 : ST_TW);
      ST_TIO:  stateNext = waitN ? ST_T3 : ST_TW;
      ST_TW:   stateNext = waitN ? ST_T3 : ST_TW;
      ST_T3:   stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  // rising edge: T-state progression
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      isIo  <= 1'b0;
      isWr  <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept) begin
        isIo <= reqType[1];
        isWr <= reqType[0];
      end
    end
  end

  // falling edge: strobe updates, half a T-state after the state change
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      memSelN <= 1'b1;
      ioSelN  <= 1'b1;
      rdN     <= 1'b1;
      wrN     <= 1'b1;
    end else begin
      memSelN <= ~(busy && !isIo);
      ioSelN  <= ~(busy && isIo);
      rdN     <= ~(busy && !isWr);
      wrN     <= ~(isWr && (state inside {ST_T2, ST_TIO, ST_TW}));
    end
  end

  assign strb.load    = accept;
  assign strb.doutEn  = busy && isWr;
  assign strb.finish  = (state == ST_T3);
  assign strb.capRead = (state == ST_T3) && !isWr;

  // R2: one target select at a time
  p_one_select_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({~memSelN, ~ioSelN}));

  // R7: read and write strobes exclusive
  p_rd_wr_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  // R4: port cycles always pass through the automatic wait state
  p_io_auto_wait_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_T2 && isIo) |=> (state == ST_TIO));

  // R10: no acceptance while a cycle runs
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_T1) |=> (state == ST_T2));

endmodule

// File: rtl/bus_cycle_dp.sv
module bus_cycle_dp
  import bus_cycle_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrb_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDin,
  input  logic              wrN,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDout,
  output logic              busDoutEn,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspDone
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAddr  <= '0;
      busDout  <= '0;
      rspRdata <= '0;
      rspDone  <= 1'b0;
    end else begin
      rspDone <= strb.finish;
      if (strb.load) begin
        busAddr <= reqAddr;
        busDout <= reqWdata;
      end
      if (strb.capRead) rspRdata <= busDin;
    end
  end

  assign busDoutEn = strb.doutEn;

  // R7: address and data hold while the write strobe is low
  p_wr_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |=> ($stable(busAddr) && $stable(busDout)));

  // R8: data is driven whenever the write strobe is low
  p_dout_en_r8: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> busDoutEn);

  // R9: done is a single-period pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_cycle_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqType,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspDone,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDout,
  output logic              busDoutEn,
  input  logic [DATA_W-1:0] busDin,
  output logic              memSelN,
  output logic              ioSelN,
  output logic              rdN,
  output logic              wrN,
  input  logic              waitN
);

  dpStrb_t strb;

  bus_cycle_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqType  (reqType),
    .waitN    (waitN),
    .strb     (strb),
    .memSelN  (memSelN),
    .ioSelN   (ioSelN),
    .rdN      (rdN),
    .wrN      (wrN)
  );

  bus_cycle_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .busDin    (busDin),
    .wrN       (wrN),
    .busAddr   (busAddr),
    .busDout   (busDout),
    .busDoutEn (busDoutEn),
    .rspRdata  (rspRdata),
    .rspDone   (rspDone)
  );

endmodule

// File: tb/bus_cycle_seq_tb.sv
`timescale 1ns/100ps
module bus_cycle_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqType = 2'b00;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic [7:0]  rspRdata, busDout, busDin;
  logic        rspDone, busDoutEn, memSelN, ioSelN, rdN, wrN;
  logic [15:0] busAddr;
  logic        waitN = 1'b1;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign busDin = busAddr[7:0] ^ 8'hA5;  // simple memory/port model

  bus_cycle_seq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspRdata(rspRdata),
    .rspDone(rspDone), .busAddr(busAddr), .busDout(busDout),
    .busDoutEn(busDoutEn), .busDin(busDin), .memSelN(memSelN),
    .ioSelN(ioSelN), .rdN(rdN), .wrN(wrN), .waitN(waitN)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: T-state index and final index of current cycle
  int          mBusy = 0, mT = 0, mFinal = 0, mIo = 0, mWr = 0, mDone = 0;
  logic [15:0] mAddr = '0;
  logic [7:0]  mDout = '0, mRdata = '0;

  always @(posedge clk) begin
    logic        reqS, waitS;
    logic [1:0]  typeS;
    logic [15:0] addrS;
    logic [7:0]  dataS;
    reqS = reqValid; waitS = waitN; typeS = reqType; addrS = reqAddr; dataS = reqWdata;
    if (!rstN) begin
      mBusy = 0; mDone = 0; mAddr = '0; mDout = '0; mRdata = '0;
    end else begin
      mDone = 0;
      if (mBusy != 0) begin
        if (mT == mFinal) begin
          mBusy = 0; mDone = 1;
          if (mWr == 0) mRdata = mAddr[7:0] ^ 8'hA5;
        end else begin
          if (mT >= (mIo != 0 ? 3 : 2) && !waitS) mFinal++;
          mT++;
        end
      end else if (reqS) begin
        mBusy = 1; mT = 1; mIo = typeS[1]; mWr = typeS[0];
        mFinal = (mIo != 0) ? 4 : 3;
        mAddr = addrS; mDout = dataS;
      end
    end
    #1;
    if (rstN) begin
      check("R8 busAddr", busAddr, mAddr);
      check("R8 busDout", busDout, mDout);
      check("R8 busDoutEn", busDoutEn, (mBusy != 0 && mWr != 0));
      check("R9 rspDone", rspDone, mDone);
      check("R9 rspRdata", rspRdata, mRdata);
    end
    #2;
    if (rstN) begin
      check("R6 R2 memSelN", memSelN, !(mBusy != 0 && mIo == 0));
      check("R6 R2 ioSelN", ioSelN, !(mBusy != 0 && mIo != 0));
      check("R6 rdN", rdN, !(mBusy != 0 && mWr == 0));
      check("R7 wrN", wrN, !(mBusy != 0 && mWr != 0 && mT >= 2 && mT < mFinal));
    end
  end

  // issue one request; kLow = clocks from T1 with waitN low; poke = mid-cycle request
  task automatic doReq(input logic [1:0] t, input logic [15:0] a, input logic [7:0] d,
                       input int kLow, input bit poke, input string tag);
    int c, lat, waits, nExp;
    @(posedge clk); #1;
    reqValid = 1'b1; reqType = t; reqAddr = a; reqWdata = d;
    waitN = (kLow == 0);
    @(posedge clk); #1;
    reqValid = 1'b0;
    c = 0;
    forever begin
      waitN = (c < kLow) ? 1'b0 : 1'b1;
      if (poke && c == 1) begin
        reqValid = 1'b1; reqType = ~t; reqAddr = ~a; reqWdata = ~d;
      end else reqValid = 1'b0;
      @(posedge clk); #1;
      c++;
      if (rspDone || c > 60) break;
    end
    reqValid = 1'b0; waitN = 1'b1;
    lat = c;
    if (t[1]) begin waits = (kLow > 2) ? kLow - 2 : 0; nExp = 4 + waits; end
    else      begin waits = (kLow > 1) ? kLow - 1 : 0; nExp = 3 + waits; end
    check({tag, " cycle length"}, lat, nExp);
    if (poke) check("R10 address kept after busy request", busAddr, a);
    if (!t[0]) check("R9 read data", rspRdata, a[7:0] ^ 8'hA5);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 memSelN reset", memSelN, 1); check("R1 ioSelN reset", ioSelN, 1);
        check("R1 rdN reset", rdN, 1);         check("R1 wrN reset", wrN, 1);
        check("R1 busDoutEn reset", busDoutEn, 0); check("R1 rspDone reset", rspDone, 0);
        check("R1 busAddr reset", busAddr, 0);
        rstN = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 idle memSelN", memSelN, 1); check("R1 idle rdN", rdN, 1);
        doReq(2'b00, 16'h1234, 8'h00, 0, 0, "R3 mem read");
        doReq(2'b01, 16'h2001, 8'h3C, 0, 0, "R3 mem write");
        doReq(2'b10, 16'h0040, 8'h00, 0, 0, "R4 io read");
        doReq(2'b11, 16'h0081, 8'hC3, 0, 0, "R4 io write");
        doReq(2'b10, 16'h0042, 8'h00, 1, 0, "R4 io wait in T2 ignored");
        doReq(2'b10, 16'h0043, 8'h00, 2, 0, "R4 io wait in T2 ignored");
        doReq(2'b00, 16'hBEEF, 8'h00, 3, 0, "R5 mem read waits");
        doReq(2'b01, 16'h7777, 8'h55, 1, 0, "R5 mem write T1 wait ignored");
        doReq(2'b01, 16'h8888, 8'hAA, 2, 0, "R5 mem write one wait");
        doReq(2'b11, 16'h00F0, 8'h99, 5, 0, "R5 io write waits");
        doReq(2'b00, 16'h4321, 8'h00, 0, 1, "R10 mem read busy request");
        doReq(2'b11, 16'h0011, 8'h66, 3, 1, "R10 io write busy request");
        for (int i = 0; i < 20; i++)
          doReq(2'(i % 4), 16'(i * 16'h1357), 8'(i * 37), i % 5, (i % 3) == 0, "R2 R5 mixed");
        repeat (4) @(posedge clk);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule